// File: doc/BRIEF.md
# Integer Arithmetic Unit with Zero Flag

This block is the arithmetic core used by register-to-register instructions. Two unsigned 16-bit operands go in. A 3-bit operation code selects addition, subtraction, low-half multiplication or unsigned division. The sum, difference, product and division results appear combinationally on `result` in the same cycle. Division has a single operation code. A separate `remEn` line makes the divide return the remainder instead of the quotient.

Comparison is subtraction combined with the `flagsLoad` strobe. On a clock edge where the strobe is high, the unit stores whether the current result is zero in a one-bit flag register. Between strobes the flag keeps its value. A conditional jump elsewhere in the processor tests this flag. The caller decides whether `result` is written back, so a compare simply does not write it. A divide with a zero divisor still gives a defined result and also raises `divByZero`.

Top module: `arith16`

## Requirements
- R1: With opSel = 3'b000, result equals (opA + opB) mod 2^16.
- R2: With opSel = 3'b001, result equals (opA - opB) mod 2^16.
- R3: With opSel = 3'b010, result equals the low 16 bits of the unsigned product opA * opB.
- R4: With opSel = 3'b011, remEn = 0 and opB not zero, result equals the unsigned quotient opA / opB.
- R5: With opSel = 3'b011, remEn = 1 and opB not zero, result equals the unsigned remainder opA % opB.
- R6: With opSel = 3'b011 and opB = 0, result is 16'hFFFF when remEn = 0 and equals opA when remEn = 1, and divByZero is 1. In every other case divByZero is 0.
- R7: On a rising clock edge with flagsLoad = 1, zeroFlag takes the value (result == 0) from that cycle. On an edge with flagsLoad = 0, zeroFlag keeps its value.
- R8: While rstN = 0, zeroFlag is 0.
- R9: remEn has no effect on result for opSel codes 3'b000, 3'b001 and 3'b010.
- R10: opSel codes 3'b100 through 3'b111 give result = 0 and divByZero = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 16 | First operand (minuend, dividend) |
| opB | input | 16 | Second operand (subtrahend, divisor) |
| opSel | input | 3 | Operation code: 0 add, 1 sub, 2 mul, 3 div |
| remEn | input | 1 | Makes the divide code return the remainder |
| flagsLoad | input | 1 | Loads the zero flag at the next edge |
| result | output | 16 | Combinational operation result |
| zeroFlag | output | 1 | Registered zero condition |
| divByZero | output | 1 | High when a divide code sees a zero divisor |

## Verification
The assertions are evaluated on every clock cycle and cover the following:
- The flag register loads on a strobe and holds between strobes.
- `divByZero` is raised exactly when it should be, together with the defined results for a zero divisor.
- Unused codes give zero.
- Addition wraps modulo 2^16.

The bench's scenarios cover the rest against an independent model:
- Arithmetic correctness of the product, quotient and remainder over many random operand pairs.
- The reset value of the flag.
- The claim that `remEn` has no effect on the non-divide codes, observed at `result`.

// File: rtl/arith16_pkg.sv
package arith16_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MUL = 3'b010,
    OP_DIV = 3'b011
  } arithOp_e;

  // strobes from control to datapath, at most one select high
  typedef struct packed {
    logic selAdd;
    logic selSub;
    logic selMul;
    logic selQuo;
    logic selRem;
    logic loadFlag;
  } arithCtrl_t;
endpackage

// File: rtl/arith16_ctrl.sv
module arith16_ctrl
  import arith16_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic       remEn,
  input  logic       flagsLoad,
  output arithCtrl_t ctrl
);
  always_comb begin
    ctrl          = '0;
    ctrl.loadFlag = flagsLoad;
    unique case (opSel)
      OP_ADD:  ctrl.selAdd = 1'b1;
      OP_SUB:  ctrl.selSub = 1'b1;
      OP_MUL:  ctrl.selMul = 1'b1;
      OP_DIV: begin
        ctrl.selQuo = ~remEn;
        ctrl.selRem = remEn;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/arith16_dp.sv
module arith16_dp
  import arith16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  arithCtrl_t   ctrl,
  output logic [W-1:0] result,
  output logic         zeroFlag,
  output logic         divByZero
);
  localparam int PW = 2 * W;

  logic [W-1:0]  sumVal, diffVal, prodLow, quoVal, remVal;
  logic [PW-1:0] prodFull;
  logic [W:0]    partial;

  assign sumVal   = opA + opB;
  assign diffVal  = opA - opB;
  assign prodFull = PW'(opA) * PW'(opB);
  assign prodLow  = prodFull[W-1:0];

  // restoring division, one quotient bit per step; a zero divisor
  // naturally yields all-ones quotient and the dividend as remainder
  always_comb begin
    quoVal  = '0;
    remVal  = '0;
    partial = '0;
    for (int i = W - 1; i >= 0; i--) begin
      partial = {remVal, opA[i]};
      if (partial >= {1'b0, opB}) begin
        partial   = partial - {1'b0, opB};
        quoVal[i] = 1'b1;
      end
      remVal = partial[W-1:0];
    end
  end

  always_comb begin
    result = '0;
    if (ctrl.selAdd) result = sumVal;
    if (ctrl.selSub) result = diffVal;
    if (ctrl.selMul) result = prodLow;
    if (ctrl.selQuo) result = quoVal;
    if (ctrl.selRem) result = remVal;
  end

  assign divByZero = (ctrl.selQuo | ctrl.selRem) & (opB == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              zeroFlag <= 1'b0;
    else if (ctrl.loadFlag) zeroFlag <= (result == '0);
  end
endmodule

// File: rtl/arith16.sv
module arith16
  import arith16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [2:0]  opSel,
  input  logic        remEn,
  input  logic        flagsLoad,
  output logic [15:0] result,
  output logic        zeroFlag,
  output logic        divByZero
);
  arithCtrl_t ctrl;

  arith16_ctrl uCtrl (
    .opSel     (opSel),
    .remEn     (remEn),
    .flagsLoad (flagsLoad),
    .ctrl      (ctrl)
  );

  arith16_dp #(.W(16)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .ctrl      (ctrl),
    .result    (result),
    .zeroFlag  (zeroFlag),
    .divByZero (divByZero)
  );
endmodule

// File: rtl/arith16_chk.sv
module arith16_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] opA,
  input logic [15:0] opB,
  input logic [2:0]  opSel,
  input logic        remEn,
  input logic        flagsLoad,
  input logic [15:0] result,
  input logic        zeroFlag,
  input logic        divByZero
);
  // R7
  flag_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagsLoad |=> (zeroFlag == ($past(result) == 16'h0)));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagsLoad |=> $stable(zeroFlag));

  // R6
  dbz_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    divByZero |-> (opSel == 3'b011 && opB == 16'h0));

  // R6
  dbz_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'b011 && opB == 16'h0) |-> divByZero);

  // R6
  dbz_quot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'b011 && opB == 16'h0 && !remEn) |-> result == 16'hFFFF);

  // R6
  dbz_rem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'b011 && opB == 16'h0 && remEn) |-> result == opA);

  // R10
  unused_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    opSel[2] |-> (result == 16'h0 && !divByZero));

  // R1
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 3'b000) |-> result == 16'(opA + opB));
endmodule

bind arith16 arith16_chk uChk (.*);

// File: tb/tb_arith16.sv
`timescale 1ns/1ps
module tb_arith16;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [2:0]  opSel = '0;
  logic        remEn = 1'b0, flagsLoad = 1'b0;
  logic [15:0] result;
  logic        zeroFlag, divByZero;

  int vecCount = 0;
  int missCount = 0;
  logic expZ = 1'b0;

  always #2 clk = ~clk;

  arith16 dut (.*);

  function automatic logic [15:0] modelRes(logic [15:0] a, logic [15:0] b,
                                           logic [2:0] op, logic r);
    logic [31:0] p;
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: begin p = {16'h0, a} * {16'h0, b}; return p[15:0]; end
      3'd3: begin
        if (b == 0) return r ? a : 16'hFFFF;
        return r ? (a % b) : (a / b);
      end
      default: return 16'h0;
    endcase
  endfunction

  function automatic string reqOf(logic [2:0] op, logic r, logic [15:0] b);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return (b == 0) ? "R6" : (r ? "R5" : "R4");
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] b, logic [2:0] op,
                       logic r, logic fl);
    logic [15:0] e;
    @(negedge clk);
    opA = a; opB = b; opSel = op; remEn = r; flagsLoad = fl;
    #1;
    e = modelRes(a, b, op, r);
    check(reqOf(op, r, b), result, e);
    check("R6", {15'h0, divByZero}, {15'h0, (op == 3'd3 && b == 0)});
    @(posedge clk);
    #1;
    if (fl) expZ = (e == 16'h0);
    check("R7", {15'h0, zeroFlag}, {15'h0, expZ});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R8", {15'h0, zeroFlag}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    apply(16'hFFFF, 16'h0001, 3'd0, 1'b0, 1'b1);   // R1 wrap to 0, R7 flag set
    apply(16'h0000, 16'h0001, 3'd1, 1'b0, 1'b0);   // R2 wrap, R7 hold
    apply(16'h1234, 16'h0100, 3'd2, 1'b0, 1'b1);   // R3 truncation, R7 clear
    apply(16'd100,  16'd7,    3'd3, 1'b0, 1'b0);   // R4
    apply(16'd100,  16'd7,    3'd3, 1'b1, 1'b0);   // R5
    apply(16'hBEEF, 16'h0000, 3'd3, 1'b0, 1'b0);   // R6 quotient
    apply(16'hBEEF, 16'h0000, 3'd3, 1'b1, 1'b0);   // R6 remainder
    apply(16'h0005, 16'h0005, 3'd1, 1'b0, 1'b1);   // R7 compare equal
    apply(16'h0005, 16'h0003, 3'd1, 1'b1, 1'b0);   // R9 remEn on sub, R7 hold
    apply(16'h00FF, 16'h0101, 3'd2, 1'b1, 1'b0);   // R9 remEn on mul
    apply(16'h7000, 16'h9000, 3'd0, 1'b1, 1'b0);   // R9 remEn on add
    apply(16'h1234, 16'h0000, 3'd5, 1'b1, 1'b1);   // R10 unused code, flag set
    apply(16'h1234, 16'h0000, 3'd7, 1'b0, 1'b0);   // R10

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a, b;
      logic [2:0]  op;
      a  = 16'($urandom);
      b  = (($urandom % 8) == 0) ? 16'h0 : 16'($urandom);
      if (($urandom % 6) == 0) b = a;
      if (($urandom % 3) == 0) b = b & 16'h00FF;
      op = (($urandom % 10) == 0) ? 3'($urandom) : 3'($urandom % 4);
      apply(a, b, op, 1'($urandom), (($urandom % 4) == 0));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule